// File: doc/BRIEF.md
# Dual Down-Counter Full-Range PWM Generator

This block produces a pulse-width-modulated output without a magnitude comparator. Two down-counters run side by side. The frame counter sets the period. It reloads from the programmed frame length whenever it reaches zero. The on-time counter reloads from the programmed on-time at that same instant. It then counts down and stops at zero. The output is high for as long as the on-time counter holds a non-zero value.

With frame length F and on-time S, a frame lasts F+1 cycles and the output is high for min(S, F+1) of them. An on-time of zero keeps the output low at all times. An on-time above F keeps it high at all times, so the duty range is complete from 0 % to 100 %.

Software may write a new on-time or frame length at any moment without stopping the generator. A written on-time is held in a shadow register and loaded only at the next frame reload. A written frame length also applies only from the next reload. This prevents any partial or glitched pulse.

Top module: `dpwm_gen`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, pwm_out is low and both counters are zero.
- R2: While enable is low, pwm_out is low and both counters are held at zero. On the first clock edge with enable high, both counters reload, so a frame begins on that edge.
- R3: With enable high, the frame counter reloads from the frame length when it is zero and otherwise decrements by one, so each frame lasts F+1 cycles.
- R4: After each reload the output is high for the first S cycles of the frame and low for the rest, when S is at most F. The on-time counter stops at zero and does not wrap.
- R5: An on-time of zero gives a continuously low output while enabled.
- R6: An on-time greater than the frame length gives a continuously high output while enabled.
- R7: An on-time write, strobed by on_time_wr, does not change the frame in progress. The new value is used from the next reload onward.
- R8: A frame length write, strobed by frame_len_wr, does not change the frame in progress. The new value sets the length of the frames that start after the next reload.
- R9: A write strobed on the same edge as a reload does not apply to that reload. The reload uses the previously held value, and the new value is used from the following reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run the generator; low clears both counters and forces the output low |
| frame_len_wr | input | 1 | Write strobe for the frame length |
| frame_len_in | input | W | New frame length F (frame lasts F+1 cycles) |
| on_time_wr | input | 1 | Write strobe for the on-time shadow register |
| on_time_in | input | W | New on-time S in cycles |
| pwm_out | output | 1 | PWM output |

## Verification
The generator is run with fixed mid-range duty settings, then with the two limit cases: on-time zero and on-time above the frame length. This separates correct saturation from a counter that wraps or a comparison that is off by one. Writes are placed in the middle of a frame and exactly on the reload edge, which distinguishes shadowed loading from immediate loading and shows whether a reload uses the old or the new value. A zero frame length, disable and re-enable in the middle of a frame, and a long random mix of writes with small values exercise reload timing against a phase-based reference.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;

    localparam int unsigned DPWM_DEF_W = 32;

    // Operation applied to both counters on a clock edge
    typedef enum logic [1:0] {
        CNT_CLEAR = 2'd0,
        CNT_LOAD  = 2'd1,
        CNT_STEP  = 2'd2
    } cnt_op_e;

endpackage

// File: rtl/dpwm_setting_regs.sv
module dpwm_setting_regs #(
    parameter int unsigned W = dpwm_pkg::DPWM_DEF_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         len_wr,
    input  logic [W-1:0] len_data,
    input  logic         on_wr,
    input  logic [W-1:0] on_data,
    output logic [W-1:0] frame_len,
    output logic [W-1:0] on_shadow
);

    typedef struct packed {
        logic [W-1:0] frame_len;
        logic [W-1:0] on_shadow;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (len_wr) begin
            regs_d.frame_len = len_data;
        end
        if (on_wr) begin
            regs_d.on_shadow = on_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign frame_len = regs_q.frame_len;
    assign on_shadow = regs_q.on_shadow;

endmodule

// File: rtl/dpwm_down_cnt.sv
module dpwm_down_cnt #(
    parameter int unsigned W        = dpwm_pkg::DPWM_DEF_W,
    parameter bit          SATURATE = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  dpwm_pkg::cnt_op_e   op,
    input  logic [W-1:0]        load_val,
    output logic [W-1:0]        cnt,
    output logic                is_zero
);

    import dpwm_pkg::*;

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic [W-1:0] step_val;
    logic         zero_now;

    assign zero_now = (st_q.cnt == '0);

    generate
        if (SATURATE) begin : g_sat
            assign step_val = zero_now ? st_q.cnt : (st_q.cnt - ONE);
        end else begin : g_wrap
            assign step_val = st_q.cnt - ONE;
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        case (op)
            CNT_CLEAR: st_d.cnt = '0;
            CNT_LOAD:  st_d.cnt = load_val;
            CNT_STEP:  st_d.cnt = step_val;
            default:   st_d.cnt = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt     = st_q.cnt;
    assign is_zero = zero_now;

endmodule

// File: rtl/dpwm_gen.sv
module dpwm_gen #(
    parameter int unsigned W = dpwm_pkg::DPWM_DEF_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         frame_len_wr,
    input  logic [W-1:0] frame_len_in,
    input  logic         on_time_wr,
    input  logic [W-1:0] on_time_in,
    output logic         pwm_out
);

    import dpwm_pkg::*;

    logic [W-1:0] frame_len;
    logic [W-1:0] on_shadow;
    logic [W-1:0] frame_cnt;
    logic [W-1:0] on_cnt;
    logic         frame_zero;
    logic         on_zero;
    cnt_op_e      op;

    dpwm_setting_regs #(.W(W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .len_wr    (frame_len_wr),
        .len_data  (frame_len_in),
        .on_wr     (on_time_wr),
        .on_data   (on_time_in),
        .frame_len (frame_len),
        .on_shadow (on_shadow)
    );

    // Shared sequencing: clear when idle, reload at frame end, else step
    always_comb begin
        if (!enable) begin
            op = CNT_CLEAR;
        end else if (frame_zero) begin
            op = CNT_LOAD;
        end else begin
            op = CNT_STEP;
        end
    end

    dpwm_down_cnt #(.W(W), .SATURATE(1'b0)) u_frame_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .load_val (frame_len),
        .cnt      (frame_cnt),
        .is_zero  (frame_zero)
    );

    dpwm_down_cnt #(.W(W), .SATURATE(1'b1)) u_on_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .load_val (on_shadow),
        .cnt      (on_cnt),
        .is_zero  (on_zero)
    );

    assign pwm_out = enable & ~on_zero;

endmodule

// File: rtl/dpwm_gen_chk.sv
module dpwm_gen_chk #(
    parameter int unsigned W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         enable,
    input logic         pwm_out,
    input logic [W-1:0] frame_cnt,
    input logic [W-1:0] on_cnt,
    input logic [W-1:0] frame_len,
    input logic [W-1:0] on_shadow
);

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    p_idle_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (frame_cnt == '0) && (on_cnt == '0));

    p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && frame_cnt == '0) |=>
            (frame_cnt == $past(frame_len)) && (on_cnt == $past(on_shadow)));

    p_frame_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && frame_cnt != '0) |=> (frame_cnt == $past(frame_cnt) - ONE));

    p_sat_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && frame_cnt != '0 && on_cnt == '0) |=> (on_cnt == '0));

    p_on_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && frame_cnt != '0 && on_cnt != '0) |=> (on_cnt == $past(on_cnt) - ONE));

    p_stays_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && frame_cnt != '0 && on_cnt > ONE) |=> (!enable || pwm_out));

endmodule

bind dpwm_gen dpwm_gen_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .pwm_out   (pwm_out),
    .frame_cnt (frame_cnt),
    .on_cnt    (on_cnt),
    .frame_len (frame_len),
    .on_shadow (on_shadow)
);

// File: tb/dpwm_gen_bench.sv
`timescale 1ns/1ps
module dpwm_gen_bench;

    localparam int unsigned W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         enable = 1'b0;
    logic         frame_len_wr = 1'b0;
    logic [W-1:0] frame_len_in = '0;
    logic         on_time_wr = 1'b0;
    logic [W-1:0] on_time_in = '0;
    logic         pwm_out;

    int n_checks = 0;
    int n_bad    = 0;

    // Phase-based reference state
    longint unsigned m_freg = 0, m_sreg = 0;
    longint unsigned m_fa = 0, m_sa = 0, m_p = 0;
    bit              m_run = 1'b0;

    always #2.5 clk = ~clk;

    dpwm_gen #(.W(W)) u_dpwm_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .frame_len_wr (frame_len_wr),
        .frame_len_in (frame_len_in),
        .on_time_wr   (on_time_wr),
        .on_time_in   (on_time_in),
        .pwm_out      (pwm_out)
    );

    function automatic bit exp_out(bit en);
        return en && m_run && (m_p < m_sa);
    endfunction

    task automatic check(string tag, logic act, logic expv);
        n_checks++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: pwm_out actual=%0b expected=%0b at %0t", tag, act, expv, $time);
        end
    endtask

    // One clock: drive inputs, advance the reference, check after the edge
    task automatic step(bit en, bit fw, longint unsigned fd, bit ow, longint unsigned od, string tag);
        @(negedge clk);
        enable       = en;
        frame_len_wr = fw;
        frame_len_in = fd[W-1:0];
        on_time_wr   = ow;
        on_time_in   = od[W-1:0];
        if (!en) begin
            m_run = 1'b0;
        end else if (!m_run || m_p == m_fa) begin
            m_p = 0; m_fa = m_freg; m_sa = m_sreg; m_run = 1'b1;
        end else begin
            m_p = m_p + 1;
        end
        if (fw) m_freg = fd;
        if (ow) m_sreg = od;
        @(posedge clk);
        #1;
        check(tag, pwm_out, exp_out(en));
    endtask

    task automatic run(bit en, int n, string tag);
        for (int i = 0; i < n; i++) step(en, 1'b0, 0, 1'b0, 0, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2024);
        // R1: reset state
        repeat (3) @(posedge clk);
        #1 check("R1 in reset", pwm_out, 1'b0);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk) #1 check("R1 after reset", pwm_out, 1'b0);

        // R2: program while disabled, output stays low
        step(1'b0, 1'b1, 9, 1'b1, 3, "R2 program idle");
        run(1'b0, 5, "R2 idle low");

        // R3/R4: mid duty, frame of 10 cycles, 3 high
        run(1'b1, 35, "R3 R4 F9 S3");

        // R5: zero on-time, R7 takes effect at next reload
        step(1'b1, 1'b0, 0, 1'b1, 0, "R7 write S0");
        run(1'b1, 25, "R5 S0 low");

        // R6: on-time above frame length
        step(1'b1, 1'b0, 0, 1'b1, 15, "R7 write S15");
        run(1'b1, 30, "R6 S15 high");

        // R7: mid-frame on-time change
        step(1'b1, 1'b0, 0, 1'b1, 6, "R7 write S6");
        run(1'b1, 25, "R7 S6");

        // R8: mid-frame frame length change
        run(1'b1, 3, "R8 pre");
        step(1'b1, 1'b1, 4, 1'b0, 0, "R8 write F4");
        run(1'b1, 20, "R8 F4");

        // R9: write exactly on a reload edge
        while (!(m_run && m_p + 1 == m_fa)) step(1'b1, 1'b0, 0, 1'b0, 0, "R9 align");
        step(1'b1, 1'b0, 0, 1'b0, 0, "R9 align last");
        step(1'b1, 1'b1, 7, 1'b1, 2, "R9 write on reload");
        run(1'b1, 25, "R9 after");

        // R2: disable mid-frame, then restart
        run(1'b1, 3, "R2 pre");
        run(1'b0, 4, "R2 disabled");
        run(1'b1, 20, "R2 restart");

        // Zero frame length: period of one cycle
        step(1'b1, 1'b1, 0, 1'b1, 1, "R6 F0 S1");
        run(1'b1, 6, "R6 F0 S1 high");
        step(1'b1, 1'b0, 0, 1'b1, 0, "R5 F0 S0");
        run(1'b1, 6, "R5 F0 S0 low");

        // Random mix, small values
        for (int i = 0; i < 600; i++) begin
            bit en, fw, ow;
            en = ($urandom % 100) < 96;
            fw = ($urandom % 100) < 8;
            ow = ($urandom % 100) < 12;
            step(en, fw, $urandom % 21, ow, $urandom % 26, "R4 random");
        end

        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule